// File: doc/BRIEF.md
# Input Capture / Compare Channel

One channel of a timer that either records the running counter value when its input pin shows a qualified edge, or compares the counter against a programmed value. In capture mode the pin is cleaned by a sampling filter that needs N agreeing samples before its output moves. The result can then be inverted, and its rising edges are detected and thinned by a divider. A surviving edge is a capture event. It copies the counter into the bus-visible register and raises a capture flag. A second capture that arrives before software clears that flag also raises an over-capture flag.

The channel keeps two value registers: a bus-facing preload register and an internal shadow register. Which way data moves between them depends on the mode. In capture mode the shadow follows the counter every cycle, and a capture event moves the shadow into the preload. In compare mode the preload feeds the shadow. The copy happens on a timer update event when buffering is enabled, or straight away on a bus write when it is not. A registered match pulse is raised while the counter equals the shadow. Bus reads and writes only ever reach the preload register.

Top module: `capcmp_channel`

## Requirements
- R1: After reset, cap_flag, ovc_flag and cmp_match are 0 and rd_data reads 0.
- R2: A cycle with wr_en high loads wr_data into the preload register, which rd_data always presents.
- R3: flt_sel selects the filter length N: 0 = bypass (one sample), 1 = 2, 2 = 4, 3 = 5, 4 = 6, 5..7 = 8. The filtered level changes only after N consecutive clock samples of the pin at the new level, so a pulse shorter than N samples causes no capture.
- R4: With pol_inv = 0 a low-to-high transition of the filtered pin is the active edge. With pol_inv = 1 a high-to-low transition is the active edge.
- R5: In capture mode (mode_cap = 1) a capture event loads the counter value of the cycle before the event into the preload register. A counter held steady for several cycles is therefore captured exactly.
- R6: psc_sel selects the capture divider: 0 passes every active edge, and 1, 2 and 3 pass every 2nd, 4th and 8th edge. The divider count restarts while mode_cap is 0.
- R7: A capture event sets cap_flag. Only a cycle with clr_cap high clears it, and a clear in the same cycle as an event leaves it set.
- R8: A capture event while cap_flag is already set also sets ovc_flag. Only clr_ovc clears it, and an event in the same cycle as the clear wins.
- R9: In compare mode with pre_en = 1, the shadow takes the preload value on an upd_evt cycle. cmp_match goes high one cycle after cnt_val equals the shadow.
- R10: In compare mode with pre_en = 0, a bus write loads the shadow in the same cycle. It has no effect on cmp_match until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the filter sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Channel input pin |
| cnt_val | input | CW | Running timer counter value |
| upd_evt | input | 1 | Timer update event, one cycle |
| mode_cap | input | 1 | 1 = capture mode, 0 = compare mode |
| flt_sel | input | 3 | Filter length select |
| pol_inv | input | 1 | Invert the filtered input before edge detection |
| psc_sel | input | 2 | Capture divider select |
| pre_en | input | 1 | Compare buffering: copy to shadow on update event |
| wr_en | input | 1 | Bus write strobe for the preload register |
| wr_data | input | CW | Bus write data |
| clr_cap | input | 1 | Write-one-to-clear strobe for cap_flag |
| clr_ovc | input | 1 | Write-one-to-clear strobe for ovc_flag |
| rd_data | output | CW | Preload register contents |
| cap_flag | output | 1 | Capture flag |
| ovc_flag | output | 1 | Over-capture flag |
| cmp_match | output | 1 | Registered compare match |

## Verification
Two situations are the hardest to reach. The first is a clear strobe that lands in exactly the cycle a capture event sets the flag. The stimulus reaches it by counting the register stages from pin to flag: with the filter bypassed, the flag is set on the second rising edge after the pin changes, so the clear is raised at the falling edge just before that one. The second is the filter boundary. It is reached with pulses held for exactly N-1 and N sampled cycles at two filter lengths, so that one sample decides whether a capture happens at all. The divider is probed by re-arming it through a compare-mode cycle and then counting pulses up to the passing one.

// File: rtl/capcmp_channel.sv
module capcmp_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_in,
  input  logic [CW-1:0] cnt_val,
  input  logic          upd_evt,
  input  logic          mode_cap,
  input  logic [2:0]    flt_sel,
  input  logic          pol_inv,
  input  logic [1:0]    psc_sel,
  input  logic          pre_en,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          clr_cap,
  input  logic          clr_ovc,
  output logic [CW-1:0] rd_data,
  output logic          cap_flag,
  output logic          ovc_flag,
  output logic          cmp_match
);
  logic [2:0]    run_len, run_q, psc_lim, psc_q;
  logic          filt_q, pol_d, pol, rise, cap_evt;
  logic [CW-1:0] preload, shadow;

  always_comb begin
    case (flt_sel)
      3'd0:    run_len = 3'd0;
      3'd1:    run_len = 3'd1;
      3'd2:    run_len = 3'd3;
      3'd3:    run_len = 3'd4;
      3'd4:    run_len = 3'd5;
      default: run_len = 3'd7;
    endcase
  end

  assign psc_lim = {psc_sel == 2'd3, psc_sel[1], |psc_sel};
  assign pol     = filt_q ^ pol_inv;
  assign rise    = pol & ~pol_d;
  assign cap_evt = mode_cap & rise & (psc_q == psc_lim);
  assign rd_data = preload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      run_q  <= '0;
    end else if (pin_in == filt_q) begin
      run_q <= '0;
    end else if (run_q == run_len) begin
      filt_q <= pin_in;
      run_q  <= '0;
    end else begin
      run_q <= run_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_d <= 1'b1;
      psc_q <= '0;
    end else begin
      pol_d <= pol;
      if (!mode_cap)  psc_q <= '0;
      else if (rise)  psc_q <= (psc_q == psc_lim) ? 3'd0 : psc_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preload <= '0;
      shadow  <= '0;
    end else if (mode_cap) begin
      shadow <= cnt_val;
      if (cap_evt)    preload <= shadow;
      else if (wr_en) preload <= wr_data;
    end else begin
      if (wr_en) preload <= wr_data;
      if (!pre_en && wr_en)       shadow <= wr_data;
      else if (pre_en && upd_evt) shadow <= preload;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_flag  <= 1'b0;
      ovc_flag  <= 1'b0;
      cmp_match <= 1'b0;
    end else begin
      cap_flag  <= (cap_flag & ~clr_cap) | cap_evt;
      ovc_flag  <= (ovc_flag & ~clr_ovc) | (cap_evt & cap_flag);
      cmp_match <= ~mode_cap & (cnt_val == shadow);
    end
  end
endmodule

// File: rtl/capcmp_channel_chk.sv
module capcmp_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_cap,
  input logic          wr_en,
  input logic          clr_cap,
  input logic          clr_ovc,
  input logic          cap_evt,
  input logic [CW-1:0] rd_data,
  input logic          cap_flag,
  input logic          ovc_flag,
  input logic          cmp_match
);
  AST_CAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_flag && !clr_cap |=> cap_flag);                              // R7
  AST_EVT_SETS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_flag);                                           // R7
  AST_OVC_NEEDS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovc_flag) |-> $past(cap_flag));                            // R8
  AST_OVC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ovc_flag && !clr_ovc |=> ovc_flag);                              // R8
  AST_RD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt && !wr_en |=> $stable(rd_data));                        // R2
  AST_MATCH_COMPARE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_match |-> $past(!mode_cap));                                 // R9
endmodule

bind capcmp_channel capcmp_channel_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_cap(mode_cap), .wr_en(wr_en),
  .clr_cap(clr_cap), .clr_ovc(clr_ovc), .cap_evt(cap_evt),
  .rd_data(rd_data), .cap_flag(cap_flag), .ovc_flag(ovc_flag),
  .cmp_match(cmp_match)
);

// File: tb/capcmp_channel_tb.sv
module capcmp_channel_tb;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pin_in = 1'b0, upd_evt = 1'b0, mode_cap = 1'b0, pol_inv = 1'b0;
  logic pre_en = 1'b0, wr_en = 1'b0, clr_cap = 1'b0, clr_ovc = 1'b0;
  logic [2:0] flt_sel = 3'd0;
  logic [1:0] psc_sel = 2'd0;
  logic [CW-1:0] cnt_val = '0, wr_data = '0, rd_data;
  logic cap_flag, ovc_flag, cmp_match;

  always #4 clk = ~clk;

  capcmp_channel #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cnt_val(cnt_val),
    .upd_evt(upd_evt), .mode_cap(mode_cap), .flt_sel(flt_sel),
    .pol_inv(pol_inv), .psc_sel(psc_sel), .pre_en(pre_en),
    .wr_en(wr_en), .wr_data(wr_data), .clr_cap(clr_cap), .clr_ovc(clr_ovc),
    .rd_data(rd_data), .cap_flag(cap_flag), .ovc_flag(ovc_flag),
    .cmp_match(cmp_match)
  );

  typedef struct {
    string       req;
    int          kind;
    logic [31:0] exp;
  } item_t;

  item_t q[$];
  event  push_ev;
  int    errors = 0, checks = 0;
  bit    done = 1'b0;

  function automatic logic [31:0] observe(int kind);
    case (kind)
      0:       return {31'd0, cap_flag};
      1:       return {31'd0, ovc_flag};
      2:       return {16'd0, rd_data};
      default: return {31'd0, cmp_match};
    endcase
  endfunction

  task automatic expect_out(string req, int kind, logic [31:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    q.push_back(it);
    ->push_ev;
  endtask

  task automatic drain();
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = observe(it.kind);
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%0h expected=%0h", it.req, act, it.exp);
      end
    end
  endtask

  initial forever begin
    @(push_ev);
    drain();
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int hi);
    @(negedge clk); pin_in = 1'b1;
    cycles(hi);
    pin_in = 1'b0;
    cycles(12);
  endtask

  task automatic clear_flags();
    @(negedge clk); clr_cap = 1'b1; clr_ovc = 1'b1;
    @(negedge clk); clr_cap = 1'b0; clr_ovc = 1'b0;
  endtask

  task automatic rearm_divider();
    @(negedge clk); mode_cap = 1'b0;
    @(negedge clk); mode_cap = 1'b1;
  endtask

  initial begin
    cycles(2);
    expect_out("R1 cap_flag", 0, 0);
    expect_out("R1 ovc_flag", 1, 0);
    expect_out("R1 rd_data", 2, 0);
    expect_out("R1 cmp_match", 3, 0);
    rst_n = 1'b1;
    cycles(2);

    // compare, buffered
    pre_en = 1'b1; wr_en = 1'b1; wr_data = 16'd50;
    @(negedge clk); wr_en = 1'b0;
    expect_out("R2 preload readback", 2, 50);
    cnt_val = 16'd50;
    cycles(2);
    expect_out("R9 no match before update", 3, 0);
    upd_evt = 1'b1;
    @(negedge clk); upd_evt = 1'b0;
    @(negedge clk);
    expect_out("R9 match after update", 3, 1);

    // compare, direct
    pre_en = 1'b0; wr_en = 1'b1; wr_data = 16'd77; cnt_val = 16'd77;
    @(negedge clk); wr_en = 1'b0;
    expect_out("R10 not yet matched", 3, 0);
    @(negedge clk);
    expect_out("R10 immediate shadow load", 3, 1);

    // capture basics
    mode_cap = 1'b1; cnt_val = 16'h1234;
    cycles(3);
    clear_flags();
    pulse(3);
    expect_out("R5 captured value", 2, 16'h1234);
    expect_out("R7 flag set", 0, 1);
    expect_out("R8 no overcapture", 1, 0);
    cnt_val = 16'h0abc;
    cycles(3);
    pulse(3);
    expect_out("R8 overcapture set", 1, 1);
    expect_out("R5 second capture", 2, 16'h0abc);
    clear_flags();
    expect_out("R7 cleared", 0, 0);
    expect_out("R8 cleared", 1, 0);

    // clear coincident with event: pin at negedge, flag set two edges later
    @(negedge clk); pin_in = 1'b1;
    @(negedge clk); clr_cap = 1'b1;
    @(negedge clk); clr_cap = 1'b0;
    expect_out("R7 event beats clear", 0, 1);
    pin_in = 1'b0;
    cycles(4);
    clear_flags();

    // filter N=4
    flt_sel = 3'd2;
    pulse(3);
    expect_out("R3 N=4 short pulse ignored", 0, 0);
    pulse(4);
    expect_out("R3 N=4 full pulse captured", 0, 1);
    clear_flags();
    // filter N=8
    flt_sel = 3'd5;
    pulse(7);
    expect_out("R3 N=8 short pulse ignored", 0, 0);
    pulse(8);
    expect_out("R3 N=8 full pulse captured", 0, 1);
    flt_sel = 3'd0;
    clear_flags();

    // divider by 4
    psc_sel = 2'd2;
    rearm_divider();
    clear_flags();
    pulse(2); pulse(2); pulse(2);
    expect_out("R6 three edges not enough", 0, 0);
    pulse(2);
    expect_out("R6 fourth edge captures", 0, 1);
    psc_sel = 2'd0;
    rearm_divider();
    clear_flags();

    // polarity
    @(negedge clk); pin_in = 1'b1;
    cycles(6);
    clear_flags();
    pol_inv = 1'b1;
    cycles(6);
    expect_out("R4 inverting high level no event", 0, 0);
    cnt_val = 16'h00f0;
    cycles(3);
    @(negedge clk); pin_in = 1'b0;
    cycles(6);
    expect_out("R4 falling pin captures", 0, 1);
    expect_out("R4 captured value", 2, 16'h00f0);

    cycles(2);
    drain();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule